// File: doc/BRIEF.md
# Fault-Tolerant Serial Byte Receiver

This block receives 8-bit asynchronous serial characters on one input line. It keeps working when a cable is unplugged, plugged back in, or bounces. The line is synchronised first. A falling edge is confirmed as a start bit at half a bit period. Each bit is then timed against an internal counter with a fixed number of clocks per bit. Every data and parity bit is sampled at its midpoint. The line must also hold one level across a guarded central window of the bit, so a character whose level moves inside a bit is thrown away instead of delivered as bad data. The stop bit (or both stop bits) must stay high across the same window.

Each character ends in exactly one one-cycle outcome pulse: a good byte with its strobe, a framing error, a parity error or a glitch error. Apart from these outcomes, a watchdog starts when a start bit is accepted. If the character and its recovery do not finish within a set number of clocks, the watchdog forces the receiver back to idle. A separate counter reports a break when the line stays low longer than the longest character. New start bits are then refused until the line has been high for a full bit period. The same rule for accepting a new start bit applies after a framing error. Parity mode and the stop-bit count are configuration inputs that are captured when a start bit is accepted.

Top module: `ft_uart_rx`

## Requirements
- R1: A low pulse on the line that no longer reads low at half a bit period after its falling edge is not taken as a start bit and produces no outcome pulse.
- R2: Characters carry 8 data bits, least significant bit first, each sampled at mid-bit. A good character raises `o_valid` for exactly one cycle with the byte on `o_data`.
- R3: `i_par_mode` selects 0 = no parity bit, 1 = even, 2 = odd and 3 = no parity bit. Even parity makes the count of ones in the data plus the parity bit even, and odd parity makes it odd. A mismatch gives a one-cycle `o_par_err` and no `o_valid`.
- R4: If the line is low anywhere in the guarded window of a stop bit, the result is a one-cycle `o_frame_err` and no `o_valid`. With `i_two_stop` = 1 both stop bits are checked.
- R5: A level change inside the guarded window of any data or parity bit gives a one-cycle `o_glitch_err` and no `o_valid`.
- R6: A watchdog loaded with `WDOG_LOAD` runs from the accepted start bit until the receiver is idle again. If it expires, the receiver returns to idle and `o_timeout` pulses for one cycle. `WDOG_LOAD` must exceed twelve bit periods.
- R7: A line held low for twelve bit periods gives a single one-cycle `o_break` pulse per low stretch, and that stretch never produces `o_valid`.
- R8: After a break, or after a framing error, no start bit is accepted until the line has been high for a full bit period.
- R9: After reset all outputs are low.
- R10: Each character produces at most one of `o_valid`, `o_frame_err`, `o_par_err` and `o_glitch_err`, never two in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_rx | input | 1 | Asynchronous serial line, high when idle |
| i_par_mode | input | 2 | Parity selection (0 none, 1 even, 2 odd, 3 none) |
| i_two_stop | input | 1 | 1 = two stop bits expected |
| o_data | output | 8 | Received byte, valid while `o_valid` is high |
| o_valid | output | 1 | One-cycle strobe for a good character |
| o_frame_err | output | 1 | Stop bit not high across its window |
| o_par_err | output | 1 | Parity mismatch |
| o_glitch_err | output | 1 | Level change inside a data or parity bit |
| o_break | output | 1 | One-cycle pulse when a break is detected |
| o_timeout | output | 1 | One-cycle pulse when the watchdog forces idle |

## Verification
The bench builds the receiver with 16 clocks per bit and a watchdog load of 256 clocks. A bit is short enough to place glitches at chosen clock offsets inside the guarded window. A break then needs only 192 low clocks. With these values the watchdog expiry, the break threshold and the end of the high-time lockout all fall within a few hundred cycles. A single run can therefore order them on purpose: for example, the watchdog fires before the break threshold is reached, or a start edge arrives while the break lockout is still active.

// File: rtl/ft_uart_rx_pkg.sv
package ft_uart_rx_pkg;

    localparam int DATA_BITS      = 8;
    // start + data + parity + two stop bits
    localparam int MAX_FRAME_BITS = 1 + DATA_BITS + 1 + 2;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_RECOVER
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic frame_err;
        logic par_err;
        logic glitch_err;
    } rx_outcome_t;

    function automatic logic parity_on(par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    // Parity bit that a correct sender places after the data
    function automatic logic parity_bit(logic [DATA_BITS-1:0] d, par_mode_e m);
        return (m == PAR_ODD) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_watchdog.sv
module rx_watchdog #(
    parameter int LOAD = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LOAD + 1);
    localparam logic [CW-1:0] LOAD_C = CW'(LOAD);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            remain  <= LOAD_C;
            expired <= 1'b0;
        end else if (remain == '0) begin
            expired <= 1'b1;
        end else begin
            remain  <= remain - 1'b1;
            expired <= 1'b0;
        end
    end

    // R6: dropping run clears the expiry on the next clock
    p_reload_clears_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !expired);

    // R6: expiry only after the count has drained
    p_expire_after_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (run && remain != '0) |=> !expired);
endmodule

// File: rtl/rx_break_det.sv
module rx_break_det #(
    parameter int LOW_CLKS  = 192,
    parameter int HIGH_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic brk_pulse,
    output logic lock
);
    localparam int LW = $clog2(LOW_CLKS + 1);
    localparam int HW = $clog2(HIGH_CLKS + 1);
    localparam logic [LW-1:0] LOW_LAST  = LW'(LOW_CLKS - 1);
    localparam logic [LW-1:0] LOW_SAT   = LW'(LOW_CLKS);
    localparam logic [HW-1:0] HIGH_LAST = HW'(HIGH_CLKS - 1);

    logic [LW-1:0] low_run;
    logic [HW-1:0] high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run   <= '0;
            high_run  <= '0;
            brk_pulse <= 1'b0;
            lock      <= 1'b0;
        end else begin
            brk_pulse <= 1'b0;
            if (line) begin
                low_run <= '0;
                if (lock) begin
                    if (high_run == HIGH_LAST) begin
                        lock     <= 1'b0;
                        high_run <= '0;
                    end else begin
                        high_run <= high_run + 1'b1;
                    end
                end
            end else begin
                high_run <= '0;
                if (low_run == LOW_LAST) begin
                    brk_pulse <= 1'b1;
                    lock      <= 1'b1;
                end
                if (low_run != LOW_SAT) low_run <= low_run + 1'b1;
            end
        end
    end

    // R7: one pulse per low stretch
    p_break_single_r7: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |=> !brk_pulse);

    // R8: a break always engages the start lockout
    p_break_locks_r8: assert property (@(posedge clk) disable iff (rst)
        brk_pulse |-> lock);

    // R8: lockout cannot release while the line is low
    p_lock_holds_low_r8: assert property (@(posedge clk) disable iff (rst)
        (lock && !line) |=> lock);
endmodule

// File: rtl/ft_uart_rx.sv
module ft_uart_rx
    import ft_uart_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int WDOG_LOAD    = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_rx,
    input  logic [1:0]           i_par_mode,
    input  logic                 i_two_stop,
    output logic [DATA_BITS-1:0] o_data,
    output logic                 o_valid,
    output logic                 o_frame_err,
    output logic                 o_par_err,
    output logic                 o_glitch_err,
    output logic                 o_break,
    output logic                 o_timeout
);
    localparam int CW        = $clog2(CLKS_PER_BIT);
    localparam int BW        = $clog2(DATA_BITS);
    localparam int BRK_CLKS  = CLKS_PER_BIT * MAX_FRAME_BITS;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID      = CW'(CLKS_PER_BIT / 2);
    localparam logic [CW-1:0] WIN_LO   = CW'(CLKS_PER_BIT / 4);
    localparam logic [CW-1:0] WIN_HI   = CW'(CLKS_PER_BIT - 1 - CLKS_PER_BIT / 4);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    if (WDOG_LOAD <= BRK_CLKS) begin : g_bad_wdog
        $error("WDOG_LOAD must exceed one maximum frame in clocks");
    end
    if (CLKS_PER_BIT < 8) begin : g_bad_cpb
        $error("CLKS_PER_BIT must be at least 8");
    end

    // ---------------- line front end ----------------
    logic rxs, rx_prev, start_edge;
    logic wd_run, wd_expired;
    logic brk_pulse, brk_lock;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (i_rx), .q (rxs)
    );

    rx_watchdog #(.LOAD(WDOG_LOAD)) u_wdog (
        .clk (clk), .rst (rst), .run (wd_run), .expired (wd_expired)
    );

    rx_break_det #(.LOW_CLKS(BRK_CLKS), .HIGH_CLKS(CLKS_PER_BIT)) u_brk (
        .clk (clk), .rst (rst), .line (rxs),
        .brk_pulse (brk_pulse), .lock (brk_lock)
    );

    assign start_edge = rx_prev & ~rxs;

    // ---------------- character state ----------------
    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 win_ref;
    logic                 moved;
    logic                 stop_low;
    logic                 second_stop;
    logic                 par_seen;
    par_mode_e            cfg_par;
    logic                 cfg_two;
    logic [CW-1:0]        hi_cnt;
    rx_outcome_t          outcome;
    logic [DATA_BITS-1:0] data_q;
    logic                 tmo_q;

    logic in_win, bit_end, stop_done, frame_bad;
    assign in_win    = (cnt >= WIN_LO) && (cnt <= WIN_HI);
    assign bit_end   = (cnt == CNT_LAST);
    assign stop_done = (cnt == WIN_HI) && (!cfg_two || second_stop);
    assign frame_bad = stop_low || !rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            win_ref     <= 1'b1;
            moved       <= 1'b0;
            stop_low    <= 1'b0;
            second_stop <= 1'b0;
            par_seen    <= 1'b0;
            cfg_par     <= PAR_NONE;
            cfg_two     <= 1'b0;
            hi_cnt      <= '0;
            wd_run      <= 1'b0;
            rx_prev     <= 1'b1;
            outcome     <= '0;
            data_q      <= '0;
            tmo_q       <= 1'b0;
        end else begin
            rx_prev <= rxs;
            outcome <= '0;
            tmo_q   <= 1'b0;
            if (wd_expired) begin
                state  <= ST_IDLE;
                wd_run <= 1'b0;
                tmo_q  <= wd_run;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (start_edge && !brk_lock) begin
                            state       <= ST_START;
                            cnt         <= '0;
                            bit_idx     <= '0;
                            moved       <= 1'b0;
                            stop_low    <= 1'b0;
                            second_stop <= 1'b0;
                            cfg_par     <= par_mode_e'(i_par_mode);
                            cfg_two     <= i_two_stop;
                            wd_run      <= 1'b1;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID && rxs) begin
                            state  <= ST_IDLE;
                            wd_run <= 1'b0;
                        end else if (bit_end) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA, ST_PAR: begin
                        if (cnt == WIN_LO)             win_ref <= rxs;
                        else if (in_win && rxs != win_ref) moved <= 1'b1;
                        if (cnt == MID) begin
                            if (state == ST_DATA) shreg    <= {rxs, shreg[DATA_BITS-1:1]};
                            else                  par_seen <= rxs;
                        end
                        if (bit_end) begin
                            cnt <= '0;
                            if (state == ST_PAR) begin
                                state <= ST_STOP;
                            end else if (bit_idx == BIT_LAST) begin
                                state <= parity_on(cfg_par) ? ST_PAR : ST_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (in_win && !rxs) stop_low <= 1'b1;
                        if (cnt == WIN_HI && frame_bad) begin
                            outcome.frame_err <= 1'b1;
                            state             <= ST_RECOVER;
                            hi_cnt            <= '0;
                        end else if (stop_done) begin
                            state  <= ST_IDLE;
                            wd_run <= 1'b0;
                            if (moved)
                                outcome.glitch_err <= 1'b1;
                            else if (parity_on(cfg_par) &&
                                     par_seen != parity_bit(shreg, cfg_par))
                                outcome.par_err <= 1'b1;
                            else begin
                                outcome.valid <= 1'b1;
                                data_q        <= shreg;
                            end
                        end else if (bit_end) begin
                            cnt         <= '0;
                            second_stop <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_RECOVER: begin
                        if (!rxs) begin
                            hi_cnt <= '0;
                        end else if (hi_cnt == CNT_LAST) begin
                            state  <= ST_IDLE;
                            wd_run <= 1'b0;
                        end else begin
                            hi_cnt <= hi_cnt + 1'b1;
                        end
                    end
                    default: begin
                        state  <= ST_IDLE;
                        wd_run <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign o_data       = data_q;
    assign o_valid      = outcome.valid;
    assign o_frame_err  = outcome.frame_err;
    assign o_par_err    = outcome.par_err;
    assign o_glitch_err = outcome.glitch_err;
    assign o_break      = brk_pulse;
    assign o_timeout    = tmo_q;

    // R10: never two outcomes at once
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({o_valid, o_frame_err, o_par_err, o_glitch_err}) <= 1);

    // R6: expiry sends the receiver to idle with the watchdog stopped
    p_timeout_idle_r6: assert property (@(posedge clk) disable iff (rst)
        wd_expired |=> (state == ST_IDLE && !wd_run));

    // R8: while the break lockout holds, idle stays idle
    p_locked_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && brk_lock && !wd_expired) |=> state == ST_IDLE);

    // R4: a framing error always leads into recovery
    p_frame_recover_r4: assert property (@(posedge clk) disable iff (rst)
        o_frame_err |-> (state == ST_RECOVER || state == ST_IDLE));

    // R6: the watchdog runs whenever a character is in progress
    p_run_in_char_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> wd_run);
endmodule

// File: tb/sim_ft_uart_rx.sv
`timescale 1ns/1ps
module sim_ft_uart_rx;
    localparam int CPB  = 16;
    localparam int WDOG = 256;

    typedef struct packed {
        logic [7:0] d;
        logic [1:0] pm;
        logic       two;
        logic       bad_par;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 2'd0, 1'b0, 1'b0},
        '{8'h00, 2'd1, 1'b0, 1'b0},
        '{8'hFF, 2'd2, 1'b0, 1'b0},
        '{8'h3C, 2'd1, 1'b1, 1'b0},
        '{8'h81, 2'd2, 1'b0, 1'b1},
        '{8'h5A, 2'd1, 1'b0, 1'b1},
        '{8'h7E, 2'd0, 1'b1, 1'b0},
        '{8'hC3, 2'd3, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx  = 1'b1;
    logic [1:0] par_mode = 2'd0;
    logic two_stop = 1'b0;
    logic [7:0] data;
    logic valid, ferr, perr, gerr, brk, tmo;

    int n_tests = 0, n_fail = 0;
    int c_valid = 0, c_ferr = 0, c_perr = 0, c_gerr = 0, c_brk = 0, c_tmo = 0;
    logic [7:0] last_byte = 8'h00;
    int s_valid, s_ferr, s_perr, s_gerr, s_brk, s_tmo;
    bit done = 0;

    always #10 clk = ~clk;

    ft_uart_rx #(.CLKS_PER_BIT(CPB), .WDOG_LOAD(WDOG)) u0 (
        .clk (clk), .rst (rst), .i_rx (rx), .i_par_mode (par_mode),
        .i_two_stop (two_stop), .o_data (data), .o_valid (valid),
        .o_frame_err (ferr), .o_par_err (perr), .o_glitch_err (gerr),
        .o_break (brk), .o_timeout (tmo)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (valid) begin c_valid++; last_byte = data; end
            if (ferr) c_ferr++;
            if (perr) c_perr++;
            if (gerr) c_gerr++;
            if (brk)  c_brk++;
            if (tmo)  c_tmo++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic snap();
        s_valid = c_valid; s_ferr = c_ferr; s_perr = c_perr;
        s_gerr = c_gerr;   s_brk = c_brk;   s_tmo = c_tmo;
    endtask

    // deltas packed as valid,ferr,perr,gerr,brk,tmo digits
    function automatic int deltas();
        return (c_valid - s_valid) * 100000 + (c_ferr - s_ferr) * 10000 +
               (c_perr - s_perr) * 1000 + (c_gerr - s_gerr) * 100 +
               (c_brk - s_brk) * 10 + (c_tmo - s_tmo);
    endfunction

    function automatic logic pbit(input logic [7:0] d, input logic [1:0] m);
        return (m == 2'd2) ? ~(^d) : (^d);
    endfunction

    task automatic send_char(input logic [7:0] d, input logic [1:0] m,
                             input logic flip_par, input logic two,
                             input logic stop1, input logic stop2);
        drive(1'b0, CPB);
        for (int i = 0; i < 8; i++) drive(d[i], CPB);
        if (m == 2'd1 || m == 2'd2) drive(pbit(d, m) ^ flip_par, CPB);
        drive(stop1, CPB);
        if (two) drive(stop2, CPB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset leaves all outputs low
        check("R9 outputs after reset",
              int'({valid, ferr, perr, gerr, brk, tmo}), 0);
        drive(1'b1, 40);

        // Table walk: R2 data/strobe, R3 parity modes
        for (int k = 0; k < NV; k++) begin
            par_mode = VECS[k].pm;
            two_stop = VECS[k].two;
            snap();
            send_char(VECS[k].d, VECS[k].pm, VECS[k].bad_par, VECS[k].two, 1'b1, 1'b1);
            drive(1'b1, 40);
            if (VECS[k].bad_par) begin
                check("R3 parity mismatch outcome", deltas(), 1000);
            end else begin
                check("R2 R3 good character outcome", deltas(), 100000);
                check("R2 byte LSB first", int'(last_byte), int'(VECS[k].d));
            end
        end
        par_mode = 2'd0;
        two_stop = 1'b0;

        // R1: short low pulse is not a start bit
        snap();
        drive(1'b0, 5);
        drive(1'b1, 200);
        check("R1 short pulse ignored", deltas(), 0);

        // R5: level moves inside data bit 3
        snap();
        drive(1'b0, CPB);
        for (int i = 0; i < 3; i++) drive(1'b1, CPB);
        drive(1'b1, 8); drive(1'b0, 2); drive(1'b1, 6);
        for (int i = 4; i < 8; i++) drive(1'b0, CPB);
        drive(1'b1, CPB);
        drive(1'b1, 40);
        check("R5 glitch inside data bit", deltas(), 100);

        // R4: short low inside the stop window
        snap();
        send_char(8'h96, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        rx = 1'b1;
        // replace tail: the stop was already sent high; send again with dip
        drive(1'b1, 40);
        snap();
        drive(1'b0, CPB);
        for (int i = 0; i < 8; i++) drive(i[0], CPB);
        drive(1'b1, 8); drive(1'b0, 2); drive(1'b1, 6);
        drive(1'b1, 40);
        check("R4 dip in stop bit", deltas(), 10000);
        // R8: after recovery a good character is accepted
        snap();
        send_char(8'h4B, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 40);
        check("R8 accepted after framing recovery", deltas(), 100000);
        check("R8 byte after recovery", int'(last_byte), 'h4B);

        // R4: second stop bit low in two-stop mode
        two_stop = 1'b1;
        snap();
        send_char(8'h21, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        drive(1'b1, 40);
        check("R4 second stop low", deltas(), 10000);
        two_stop = 1'b0;

        // R6: stop low, line stays low past the watchdog but short of a break
        snap();
        send_char(8'h55, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 130);
        drive(1'b1, 60);
        check("R6 watchdog expiry", deltas(), 10001);

        // R7: break, then R8 start edge inside lockout is refused
        snap();
        drive(1'b0, 300);
        check("R7 break reported once, no byte", (c_brk - s_brk) * 10 + (c_valid - s_valid), 10);
        drive(1'b1, 10);
        snap();
        drive(1'b0, 9 * CPB);
        drive(1'b1, 60);
        check("R8 start refused during lockout", deltas(), 0);
        snap();
        send_char(8'hE1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 40);
        check("R7 R10 receive after break", deltas(), 100000);
        check("R7 byte after break", int'(last_byte), 'hE1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule